// File: doc/BRIEF.md
# Eight-Pin Programmable I/O Bank

This block is one bank of general-purpose pins, up to eight of them, controlled through four byte-wide registers. They sit at consecutive indexes of a shared register space, starting at a 4-aligned base index that is set by a parameter. The four registers are direction, output value, sampled pin level and drive style. The drive-style register sets each pin to open-drain or push-pull.

Every pin drives a pad controller with three signals: the value, an enable and an open-drain flag. Each pin also receives a pad level, which a chain of two flops synchronises. The block also presents, for each pin, the level a host should see. For an output pin this is the programmed value. For an input pin it is the synchronised pad level.

Several instances can share one index/data bus, each at its own base index (for example 0xF0, 0xE0, 0xD0 and downward, or 0x88). A bank that misses the index returns zero, so the read data of all banks can be ORed together.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous reset, all pins are inputs, the output value is 0 and the drive style is open-drain. Every register reads 0, `pad_oe` is 0 and `pad_od` is all ones.
- R2: Registers decode at BASE+0 (direction), BASE+1 (output value), BASE+2 (pin level) and BASE+3 (drive style). A read of any other index returns 0 one cycle later, and a write to any other index changes nothing.
- R3: A direction bit of 1 makes the pin an output and 0 makes it an input. A pin whose direction bit is 0 never has `pad_oe` set.
- R4: A drive-style bit of 0 selects open-drain. For such a pin `pad_od` is 1, and `pad_oe` is 1 only when the pin is an output and its output-value bit is 0.
- R5: A drive-style bit of 1 selects push-pull. For such a pin `pad_od` is 0, and `pad_oe` equals its direction bit.
- R6: `pad_out` carries the output-value register. Pad outputs change on the clock edge after the register write takes effect.
- R7: The pin-level register shows `pad_in` through two flops: a change is read back by a read issued two cycles later, but not by one issued one cycle later. The register is read-only, and writes to it are ignored.
- R8: Register bits at or above PIN_COUNT read as 0, and writes to them are ignored.
- R9: `pin_val` gives, for each pin, its output-value bit when the pin is an output and its synchronised pad level when it is an input.
- R10: A read and a write to the same index in the same cycle return the value the register held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | IDX_W | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the strobe, 0 on a miss |
| reg_rvalid | output | 1 | Pulses one cycle after `reg_rd` |
| pad_in | input | PIN_COUNT | Asynchronous pad levels |
| pad_out | output | PIN_COUNT | Pad drive value |
| pad_oe | output | PIN_COUNT | Pad drive enable |
| pad_od | output | PIN_COUNT | Pad open-drain select |
| pin_val | output | PIN_COUNT | Host-visible pin value |

## Verification
Two operations can fall in the same cycle: a register write and a read of the same register, or a pad level change and a read of the pin-level register. The bench provokes the first by strobing write and read together on the output-value index. The second it provokes by changing `pad_in` one cycle, and then two cycles, before a read of the pin-level register. A scoreboard of expected read data judges the results. A same-cycle read must give the old value, and the pad change must first appear in the second read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    OFS_DIR  = 2'd0,
    OFS_OUT  = 2'd1,
    OFS_PIN  = 2'd2,
    OFS_MODE = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int CW = $clog2(STAGES + 1);

  logic [STAGES-1:0][W-1:0] chain;
  logic [CW-1:0]            warm;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)                      warm <= '0;
    else if (warm != CW'(STAGES)) warm <= warm + 1'b1;
  end

  if (STAGES == 2) begin : g_chk2
    // R7: the synchronised level equals the pad level of two edges earlier
    p_sync_delay_r7: assert property (@(posedge clk) disable iff (rst)
      (warm == CW'(STAGES)) |-> (dout == $past(din, 2)));
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int                 PIN_COUNT = 8,
  parameter int                 IDX_W     = 8,
  parameter logic [IDX_W-1:0]   BASE_IDX  = 'hF0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [REG_W-1:0]     wdata,
  input  logic [PIN_COUNT-1:0] pin_state,
  output logic [PIN_COUNT-1:0] dir_q,
  output logic [PIN_COUNT-1:0] dout_q,
  output logic [PIN_COUNT-1:0] mode_q,
  output logic                 rvalid,
  output logic [REG_W-1:0]     rdata
);
  logic                 hit;
  reg_ofs_e             ofs;
  logic [PIN_COUNT-1:0] sel;
  logic [REG_W-1:0]     sel_ext;

  assign hit = (idx[IDX_W-1:2] == BASE_IDX[IDX_W-1:2]);
  assign ofs = reg_ofs_e'(idx[1:0]);

  always_comb begin
    case (ofs)
      OFS_DIR:  sel = dir_q;
      OFS_OUT:  sel = dout_q;
      OFS_PIN:  sel = pin_state;
      default:  sel = mode_q;
    endcase
    sel_ext = '0;
    sel_ext[PIN_COUNT-1:0] = sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      dout_q <= '0;
      mode_q <= '0;
    end else if (wr_en && hit) begin
      case (ofs)
        OFS_DIR:  dir_q  <= wdata[PIN_COUNT-1:0];
        OFS_OUT:  dout_q <= wdata[PIN_COUNT-1:0];
        OFS_MODE: mode_q <= wdata[PIN_COUNT-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      rdata  <= (rd_en && hit) ? sel_ext : '0;
    end
  end

  if (PIN_COUNT < REG_W) begin : g_chk_pad
    // R8: unimplemented bit positions always read zero
    p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (rst)
      rvalid |-> (rdata[REG_W-1:PIN_COUNT] == '0));
  end

  // R2: a read that missed the bank returns zero
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && !$past(hit)) |-> (rdata == '0));
endmodule

// File: rtl/gpio_bank_pad.sv
module gpio_bank_pad #(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PIN_COUNT-1:0] dir_q,
  input  logic [PIN_COUNT-1:0] dout_q,
  input  logic [PIN_COUNT-1:0] mode_q,
  input  logic [PIN_COUNT-1:0] pin_state,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_oe,
  output logic [PIN_COUNT-1:0] pad_od,
  output logic [PIN_COUNT-1:0] pin_val
);
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    logic drive_en;
    assign drive_en = dir_q[i] & (mode_q[i] | ~dout_q[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
        pad_od[i]  <= 1'b1;
        pin_val[i] <= 1'b0;
      end else begin
        pad_out[i] <= dout_q[i];
        pad_oe[i]  <= drive_en;
        pad_od[i]  <= ~mode_q[i];
        pin_val[i] <= dir_q[i] ? dout_q[i] : pin_state[i];
      end
    end

    // R3: an input pin is never driven
    p_oe_needs_dir_r3: assert property (@(posedge clk) disable iff (rst)
      pad_oe[i] |-> $past(dir_q[i]));
    // R4: an open-drain pin is driven only to low
    p_od_low_only_r4: assert property (@(posedge clk) disable iff (rst)
      (pad_oe[i] && pad_od[i]) |-> !pad_out[i]);
    // R5: a push-pull output pin is always driven
    p_pp_drive_r5: assert property (@(posedge clk) disable iff (rst)
      (!pad_od[i] && $past(dir_q[i])) |-> pad_oe[i]);
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int               PIN_COUNT   = 8,
  parameter int               IDX_W       = 8,
  parameter logic [IDX_W-1:0] BASE_IDX    = 'hF0,
  parameter int               SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IDX_W-1:0]     reg_idx,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 reg_rvalid,
  input  logic [PIN_COUNT-1:0] pad_in,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_oe,
  output logic [PIN_COUNT-1:0] pad_od,
  output logic [PIN_COUNT-1:0] pin_val
);
  logic [PIN_COUNT-1:0] pin_state;
  logic [PIN_COUNT-1:0] dir_q;
  logic [PIN_COUNT-1:0] dout_q;
  logic [PIN_COUNT-1:0] mode_q;

  gpio_bank_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(pin_state)
  );

  gpio_bank_regs #(.PIN_COUNT(PIN_COUNT), .IDX_W(IDX_W), .BASE_IDX(BASE_IDX)) u_regs (
    .clk(clk), .rst(rst), .idx(reg_idx), .wr_en(reg_wr), .rd_en(reg_rd),
    .wdata(reg_wdata), .pin_state(pin_state), .dir_q(dir_q), .dout_q(dout_q),
    .mode_q(mode_q), .rvalid(reg_rvalid), .rdata(reg_rdata)
  );

  gpio_bank_pad #(.PIN_COUNT(PIN_COUNT)) u_pad (
    .clk(clk), .rst(rst), .dir_q(dir_q), .dout_q(dout_q), .mode_q(mode_q),
    .pin_state(pin_state), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_od(pad_od), .pin_val(pin_val)
  );
endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  localparam int         N    = 6;
  localparam logic [7:0] BASE = 8'hD0;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   reg_idx = '0;
  logic         reg_wr = 1'b0;
  logic         reg_rd = 1'b0;
  logic [7:0]   reg_wdata = '0;
  logic [7:0]   reg_rdata;
  logic         reg_rvalid;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, pad_od, pin_val;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  typedef struct { logic [7:0] exp; string req; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  gpio_bank #(.PIN_COUNT(N), .IDX_W(8), .BASE_IDX(BASE), .SYNC_STAGES(2)) i_gpio_bank (
    .clk(clk), .rst(rst), .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
    .pin_val(pin_val)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // driver: one bus cycle, expected read data goes to the scoreboard
  task automatic bus(bit wr, bit rd, logic [7:0] idx, logic [7:0] wd,
                     logic [7:0] exp, string req);
    exp_t e;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_idx = idx; reg_wdata = wd;
    if (rd) begin
      e.exp = exp; e.req = req;
      sb.push_back(e);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic wr(logic [7:0] idx, logic [7:0] wd);
    bus(1'b1, 1'b0, idx, wd, 8'h00, "");
    idle();
    @(negedge clk);
  endtask

  task automatic rd(logic [7:0] idx, logic [7:0] exp, string req);
    bus(1'b0, 1'b1, idx, 8'h00, exp, req);
    idle();
  endtask

  // monitor: compares read results against the scoreboard
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      if (sb.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R2: unexpected read data %02h expected none", reg_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.req, reg_rdata, e.exp);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", 8'(pad_oe), 8'h00);
    chk("R1", 8'(pad_od), 8'h3F);
    rd(BASE + 8'd0, 8'h00, "R1");
    rd(BASE + 8'd1, 8'h00, "R1");
    rd(BASE + 8'd3, 8'h00, "R1");
    // R8, R4: all pins output, open-drain, data 0
    wr(BASE + 8'd0, 8'hFF);
    rd(BASE + 8'd0, 8'h3F, "R8");
    chk("R4", 8'(pad_oe), 8'h3F);
    chk("R4", 8'(pad_od), 8'h3F);
    // R6, R4: open-drain releases pins whose data bit is 1
    wr(BASE + 8'd1, 8'h15);
    chk("R6", 8'(pad_out), 8'h15);
    chk("R4", 8'(pad_oe), 8'h2A);
    rd(BASE + 8'd1, 8'h15, "R2");
    // R5 push-pull
    wr(BASE + 8'd3, 8'h3F);
    chk("R5", 8'(pad_oe), 8'h3F);
    chk("R5", 8'(pad_od), 8'h00);
    // R3, R9: pins 4 and 5 become inputs
    pad_in = 6'h30;
    wr(BASE + 8'd0, 8'h0F);
    repeat (3) @(negedge clk);
    chk("R3", 8'(pad_oe), 8'h0F);
    chk("R9", 8'(pin_val), 8'h35);
    // R7 synchroniser latency, same-cycle pad change and read
    pad_in = 6'h2A;
    bus(1'b0, 1'b1, BASE + 8'd2, 8'h00, 8'h30, "R7");
    bus(1'b0, 1'b1, BASE + 8'd2, 8'h00, 8'h2A, "R7");
    idle();
    @(negedge clk);
    chk("R9", 8'(pin_val), 8'h25);
    // R7 pin-level register is read-only
    wr(BASE + 8'd2, 8'hFF);
    rd(BASE + 8'd2, 8'h2A, "R7");
    // R10 read during write returns the old value
    bus(1'b1, 1'b1, BASE + 8'd1, 8'h3C, 8'h15, "R10");
    idle();
    rd(BASE + 8'd1, 8'h3C, "R10");
    // R2 writes and reads outside the bank
    wr(BASE + 8'd4, 8'hFF);
    wr(8'hE0, 8'h00);
    rd(BASE + 8'd4, 8'h00, "R2");
    rd(8'hE0, 8'h00, "R2");
    rd(BASE + 8'd0, 8'h0F, "R2");
    rd(BASE + 8'd3, 8'h3F, "R2");
    // R8 writes to unimplemented bits are ignored
    wr(BASE + 8'd1, 8'hC0);
    rd(BASE + 8'd1, 8'h00, "R8");
    chk("R8", 8'(pad_out), 8'h00);
    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R2: actual %0d reads pending expected 0", sb.size());
    end
    finish_run();
  end
endmodule